// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the 32-bit program counter of a simple in-order core and works out, every cycle, where the next fetch goes. It looks at the instruction word that has just been fetched and at the two register operand values read for it. From the 6-bit major opcode in the top bits, and from the function field of register-format words, it chooses one of four kinds of next address. The first is the sequential address. The second is a conditional branch relative to the address after the branch, taken on equal or on not-equal operands. The third is a jump that stays within the current 256 MB region, with or without a link. The fourth is a jump to the full value of the first register operand.

Decoding produces one of six named transfer kinds: XFER_SEQ, XFER_BEQ, XFER_BNE, XFER_JUMP, XFER_JAL and XFER_JR. The selector turns each kind into a next-PC choice through a single case statement. The PC register has two transitions. Reset loads the reset vector. An enabled edge loads the selected next PC, and the register holds when the enable is low. A jump-and-link also drives a link-write strobe for that cycle, together with register index 31 and the return address. The surrounding pipeline uses these to write the link register.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high `rst` loads `pc` with the reset vector (default 0) on the next rising edge.
- R2: While `en` is low, `pc` keeps its value across a rising edge, whatever the instruction.
- R3: Any opcode in `instr[31:26]` other than 0, 2, 3, 4 or 5, and opcode 0 with a function field `instr[5:0]` other than 0x08, moves `pc` to `pc + 4`.
- R4: Opcode 4 (branch on equal) with `rs_val == rt_val` moves `pc` to `pc + 4 + (sign-extended instr[15:0] * 4)`. With unequal operands it moves `pc` to `pc + 4`.
- R5: Opcode 5 (branch on not-equal) takes the same relative target when `rs_val != rt_val`, and moves `pc` to `pc + 4` when the operands are equal.
- R6: The branch offset is two's complement: an immediate of 0xFFFF lands back on the branch itself, and 0x8000 reaches 2^15 words below `pc + 4`.
- R7: Opcode 2 (jump) moves `pc` to `{pc[31:28], instr[25:0], 2'b00}`.
- R8: Opcode 3 (jump and link) forms the same target as R7. In that cycle, while `en` is high, it raises `link_we` and drives `link_idx` = 31 and `link_val` = `pc + 4`.
- R9: Opcode 0 with function field 0x08 (jump to register) moves `pc` to the full 32-bit `rs_val`.
- R10: `link_we` is low for every instruction other than opcode 3, and it is low whenever `en` is low.
- R11: A region jump (opcodes 2 and 3) leaves `pc[31:28]` unchanged, even when the target field is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; PC holds while low |
| instr | input | 32 | Fetched instruction word |
| rs_val | input | 32 | First register operand value |
| rt_val | input | 32 | Second register operand value |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Link-register write strobe (jump and link) |
| link_idx | output | 5 | Link destination register index |
| link_val | output | 32 | Return address, current PC + 4 |

## Verification
A jump-and-link does two things in the same cycle. It drives the link write, whose value is the current PC plus 4, and it redirects the PC to a target spliced from that same PC's high bits. The bench presents such words, both at region-crossing high PCs and with `en` low. It checks the strobe, index and return address before the edge, and the spliced PC after it, against a reference model. The two branch opcodes also coincide with operand equality. The bench drives each with equal and with unequal operands, including a negative offset, so a swapped comparison or a missing sign extension shows up in the next PC.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int INSTR_W = 32;
    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OP_JUMP    = 6'd2;
    localparam logic [OP_W-1:0] OP_JAL     = 6'd3;
    localparam logic [OP_W-1:0] OP_BEQ     = 6'd4;
    localparam logic [OP_W-1:0] OP_BNE     = 6'd5;
    localparam logic [FN_W-1:0] FN_JR      = 6'h08;

    typedef enum logic [2:0] {
        XFER_SEQ,
        XFER_BEQ,
        XFER_BNE,
        XFER_JUMP,
        XFER_JAL,
        XFER_JR
    } xfer_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic [FN_W-1:0] fn,
    output xfer_e           kind
);
    always_comb begin
        unique case (op)
            OP_SPECIAL: kind = (fn == FN_JR) ? XFER_JR : XFER_SEQ;
            OP_JUMP:    kind = XFER_JUMP;
            OP_JAL:     kind = XFER_JAL;
            OP_BEQ:     kind = XFER_BEQ;
            OP_BNE:     kind = XFER_BNE;
            default:    kind = XFER_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TGT_W-1:0] field,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  br_pc,
    output logic [PC_W-1:0]  region_pc
);
    localparam int REG_W = PC_W - TGT_W - 2;
    localparam int EXT_W = PC_W - IMM_W - 2;

    logic [IMM_W-1:0] imm;
    logic [PC_W-1:0]  offset;

    always_comb begin
        imm       = field[IMM_W-1:0];
        offset    = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        seq_pc    = pc + PC_W'(4);
        br_pc     = seq_pc + offset;
        region_pc = {pc[PC_W-1 -: REG_W], field, 2'b00};
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  xfer_e           kind,
    input  logic [PC_W-1:0] rs_val,
    input  logic [PC_W-1:0] rt_val,
    input  logic [PC_W-1:0] seq_pc,
    input  logic [PC_W-1:0] br_pc,
    input  logic [PC_W-1:0] region_pc,
    output logic [PC_W-1:0] next_pc
);
    logic same;

    always_comb begin
        same = (rs_val == rt_val);
        unique case (kind)
            XFER_SEQ:  next_pc = seq_pc;
            XFER_BEQ:  next_pc = same ? br_pc : seq_pc;
            XFER_BNE:  next_pc = same ? seq_pc : br_pc;
            XFER_JUMP: next_pc = region_pc;
            XFER_JAL:  next_pc = region_pc;
            XFER_JR:   next_pc = rs_val;
            default:   next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int          PC_W      = 32,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000,
    parameter int          IDX_W     = 5,
    parameter int          LINK_REG  = 31
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [INSTR_W-1:0] instr,
    input  logic [PC_W-1:0]    rs_val,
    input  logic [PC_W-1:0]    rt_val,
    output logic [PC_W-1:0]    pc,
    output logic               link_we,
    output logic [IDX_W-1:0]   link_idx,
    output logic [PC_W-1:0]    link_val
);
    xfer_e            kind;
    logic [PC_W-1:0]  seq_pc;
    logic [PC_W-1:0]  br_pc;
    logic [PC_W-1:0]  region_pc;
    logic [PC_W-1:0]  next_pc;

    npc_decode u_dec (
        .op   (instr[INSTR_W-1 -: OP_W]),
        .fn   (instr[FN_W-1:0]),
        .kind (kind)
    );

    npc_target #(.PC_W(PC_W)) u_tgt (
        .pc        (pc),
        .field     (instr[TGT_W-1:0]),
        .seq_pc    (seq_pc),
        .br_pc     (br_pc),
        .region_pc (region_pc)
    );

    npc_select #(.PC_W(PC_W)) u_sel (
        .kind      (kind),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .seq_pc    (seq_pc),
        .br_pc     (br_pc),
        .region_pc (region_pc),
        .next_pc   (next_pc)
    );

    // PC register: reset vector on reset, next PC on enabled edge
    always_ff @(posedge clk) begin
        if (rst)
            pc <= RESET_VEC[PC_W-1:0];
        else if (en)
            pc <= next_pc;
    end

    always_comb begin
        link_we  = en && (kind == XFER_JAL);
        link_idx = IDX_W'(LINK_REG);
        link_val = seq_pc;
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int          PC_W      = 32,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input logic            clk,
    input logic            rst,
    input logic            en,
    input logic [31:0]     instr,
    input logic [PC_W-1:0] rs_val,
    input logic [PC_W-1:0] pc,
    input logic            link_we
);
    logic [5:0] op;
    logic [5:0] fn;
    logic       plain;
    assign op    = instr[31:26];
    assign fn    = instr[5:0];
    assign plain = (op > 6'd5) || (op == 6'd1) || (op == 6'd0 && fn != 6'h08);

    // R1
    reset_load_chk: assert property (@(posedge clk) rst |=> pc == RESET_VEC[PC_W-1:0]);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> pc == $past(pc));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && plain) |=> pc == $past(pc) + PC_W'(4));

    // R9
    reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op == 6'd0 && fn == 6'h08) |=> pc == $past(rs_val));

    // R10
    link_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!en || op != 6'd3) |-> !link_we);

    // R11
    region_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (op == 6'd2 || op == 6'd3)) |=> pc[PC_W-1 -: 4] == $past(pc[PC_W-1 -: 4]));
endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .instr   (instr),
    .rs_val  (rs_val),
    .pc      (pc),
    .link_we (link_we)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_val;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] exp_pc;

    always #5 clk = ~clk;

    npc_unit uut (
        .clk(clk), .rst(rst), .en(en), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .pc(pc), .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
    );

    function automatic logic [31:0] model_next(input logic [31:0] cur, input logic [31:0] w,
                                               input logic [31:0] a, input logic [31:0] b);
        int unsigned op = w[31:26];
        int signed   words = $signed(w[15:0]);
        logic [31:0] after = cur + 32'd4;
        logic [31:0] far = after + 32'(words * 4);
        if (op == 4) return (a == b) ? far : after;
        if (op == 5) return (a != b) ? far : after;
        if (op == 2 || op == 3) return (cur & 32'hF000_0000) | ({6'b0, w[25:0]} << 2);
        if (op == 0 && w[5:0] == 6'h08) return a;
        return after;
    endfunction

    function automatic string tag_of(input logic [31:0] w);
        case (w[31:26])
            6'd2: return "R7";
            6'd3: return "R8";
            6'd4: return "R4";
            6'd5: return "R5";
            6'd0: return (w[5:0] == 6'h08) ? "R9" : "R3";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        @(posedge clk); #1;
        exp_pc = 32'h0;
        check("R1", pc, exp_pc);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one instruction: drive at negedge, check link outputs mid-cycle, PC after edge
    task automatic step(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                        input bit e, input string req);
        bit jal;
        instr = w; rs_val = a; rt_val = b; en = e;
        #1;
        jal = e && (w[31:26] == 6'd3);
        check(jal ? "R8" : "R10", {31'b0, link_we}, {31'b0, jal});
        if (jal) begin
            check("R8", {27'b0, link_idx}, 32'd31);
            check("R8", link_val, exp_pc + 32'd4);
        end
        if (e) exp_pc = model_next(exp_pc, w, a, b);
        @(posedge clk); #1;
        check(req, pc, exp_pc);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        exp_pc = 32'h0;
        do_reset();
        step(32'h2108_0001, 0, 0, 1, "R3");                // opcode 8
        step(32'h0109_4020, 0, 0, 1, "R3");                // opcode 0, funct 0x20
        step({6'd4, 10'd0, 16'd3}, 7, 7, 1, "R4");          // taken, +3 words
        step({6'd4, 10'd0, 16'd3}, 7, 8, 1, "R4");          // not taken
        step({6'd5, 10'd0, 16'hFFFF}, 1, 2, 1, "R6");       // lands on itself
        step({6'd5, 10'd0, 16'd9}, 5, 5, 1, "R5");          // equal: not taken
        step({6'd5, 10'd0, 16'd9}, 5, 6, 1, "R5");          // differ: taken
        step({6'd2, 26'h00034F8}, 0, 0, 1, "R7");
        step({6'd0, 20'd0, 6'h08}, 32'hA000_1000, 0, 1, "R9");
        step({6'd4, 10'd0, 16'h8000}, 3, 3, 1, "R6");       // -2^15 words
        step({6'd2, 26'h3FF_FFFF}, 0, 0, 1, "R11");
        step({6'd3, 26'h0000040}, 0, 0, 1, "R8");
        step({6'd3, 26'h0000080}, 0, 0, 0, "R2");           // en low: hold, no strobe
        step({6'd0, 20'd0, 6'h08}, 32'h1234_5678, 0, 0, "R2");
        step({6'd0, 20'd0, 6'h08}, 32'hF000_0000, 0, 1, "R9");
        step({6'd3, 26'h3FF_FFFF}, 0, 0, 1, "R11");
        step({6'd2, 26'h0000010}, 0, 0, 1, "R7");
        do_reset();
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w = $urandom;
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom_range(0, 1) ? a : $urandom;
            bit e = ($urandom_range(0, 7) != 0);
            case ($urandom_range(0, 5))
                0: w[31:26] = 6'd4;
                1: w[31:26] = 6'd5;
                2: w[31:26] = 6'd2;
                3: w[31:26] = 6'd3;
                4: begin w[31:26] = 6'd0; if (i % 2 == 0) w[5:0] = 6'h08; end
                default: ;
            endcase
            step(w, a, b, e, e ? tag_of(w) : "R2");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule